// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous dual-port memory with two symmetric ports, left and right. Both ports run from a common clock. Each port has an address, a write-data word, a read-data word, one byte-select per 8-bit lane and a write strobe. A port is selected only when both of its chip enables agree: the active-low one is low and the active-high one is high. Reads come out through a two-register pipeline. An asynchronous output enable forces the read data to zero while it is high.

The two highest words double as mailboxes, one per port. When one port writes the other port's mailbox, the receiving port's active-low interrupt goes low. The interrupt returns high once the receiving port reads its own mailbox. This lets two agents on the two ports pass short messages without polling.

The block also detects a collision, which is both ports selected at the same address on the same clock edge. Each collision sends a one-cycle pulse down a fixed delay line, and the pulse appears on both busy outputs several cycles later.

Top module: `dpram_mailbox`

## Requirements
- R1: A port takes part in reads, writes, mailbox events and collisions only when its `ce_n` is 0 and its `ce` is 1 on the sampling edge. Any other combination leaves memory, read data, interrupts and busy untouched.
- R2: A selected read (`we`=0) whose inputs are sampled on edge k shows the word on `rdata` after edge k+1. The word is the content from before any write on that same edge. `rdata` holds its value until the next selected read of that port.
- R3: A selected write (`we`=1) changes only the byte lanes whose `be` bit is 1. Lane i is data bits [8i+7:8i].
- R4: On a selected read, lanes whose `be` bit is 0 read as zero.
- R5: While a port's `oe_n` is 1, its `rdata` is all zeros, and this takes effect without any clock edge. When `oe_n` is 0, `rdata` shows the pipelined word.
- R6: The left mailbox is the all-ones address and the right mailbox is the all-ones address minus one. A selected right write with at least one `be` bit set to the left mailbox, sampled on edge k, drives `l_irq_n` to 0 after edge k+1. The same rule holds in the mirrored direction for `r_irq_n`.
- R7: A selected read by a port of its own mailbox, sampled on edge k, returns that port's `irq_n` to 1 after edge k+1. A raise and a clear on the same edge leave the interrupt low. A port writing its own mailbox does not change its interrupt.
- R8: When both ports are selected with equal addresses on edge k, `l_busy` and `r_busy` are both 1 for exactly the one cycle after edge k+5. Each colliding edge gives its own pulse.
- R9: When both ports write the same address on the same edge, each lane enabled on the left takes the left data. Lanes enabled only on the right take the right data.
- R10: After reset both interrupts are 1, both busy outputs are 0 and both read-data words are 0. Memory contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | 8*LANES | Left write data |
| l_be | input | LANES | Left byte-lane selects |
| l_rdata | output | 8*LANES | Left read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| l_busy | output | 1 | Delayed collision pulse seen by the left port |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | 8*LANES | Right write data |
| r_be | input | LANES | Right byte-lane selects |
| r_rdata | output | 8*LANES | Right read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |
| r_busy | output | 1 | Delayed collision pulse seen by the right port |

## Verification
Inputs sampled on edge k produce read data and interrupt changes after edge k+1, and busy pulses after edge k+5. The output-enable gating needs no edge at all. The bench drives each input set on a falling edge. It then checks the outputs on every following falling edge against a model that advances once per edge, so each result is compared in the half-cycle where it is due. A five-entry shift of expected collision flags in the bench supplies the busy timing. The output-enable gating is checked one nanosecond after the output enable is toggled in mid-cycle.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;
  typedef enum logic { OWNER_LEFT = 1'b0, OWNER_RIGHT = 1'b1 } owner_e;

  // Mailbox word owned by a port: left at the top, right just below it.
  function automatic int unsigned mbox_index(input owner_e owner, input int unsigned aw);
    return ((1 << aw) - 1) - ((owner == OWNER_RIGHT) ? 1 : 0);
  endfunction
endpackage

// File: rtl/dpm_port_reg.sv
`timescale 1ns/1ps
module dpm_port_reg #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               ce,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [LANES*8-1:0] wdata,
  input  logic [LANES-1:0]   be,
  output logic               sel_q,
  output logic               we_q,
  output logic [AW-1:0]      addr_q,
  output logic [LANES*8-1:0] wdata_q,
  output logic [LANES-1:0]   be_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      sel_q   <= !ce_n && ce;
      we_q    <= we;
      addr_q  <= addr;
      wdata_q <= wdata;
      be_q    <= be;
    end
  end
endmodule

// File: rtl/dpm_array.sv
`timescale 1ns/1ps
module dpm_array #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l_sel,
  input  logic               l_we,
  input  logic [AW-1:0]      l_addr,
  input  logic [LANES*8-1:0] l_wdata,
  input  logic [LANES-1:0]   l_be,
  input  logic               r_sel,
  input  logic               r_we,
  input  logic [AW-1:0]      r_addr,
  input  logic [LANES*8-1:0] r_wdata,
  input  logic [LANES-1:0]   r_be,
  output logic [LANES*8-1:0] l_rd,
  output logic [LANES*8-1:0] r_rd
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * 8;

  logic [LANES-1:0][7:0] mem [DEPTH];

  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Right lanes first, left lanes after: the left port wins a shared lane.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (r_sel && r_we && r_be[i]) mem[r_addr][i] <= r_wdata[i*8 +: 8];
      if (l_sel && l_we && l_be[i]) mem[l_addr][i] <= l_wdata[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rd <= '0;
      r_rd <= '0;
    end else begin
      if (l_sel && !l_we) l_rd <= mem[l_addr] & lane_mask(l_be);
      if (r_sel && !r_we) r_rd <= mem[r_addr] & lane_mask(r_be);
    end
  end
endmodule

// File: rtl/dpm_mailbox.sv
`timescale 1ns/1ps
module dpm_mailbox #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          l_any_be,
  input  logic          r_sel,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_any_be,
  output logic          set_l,
  output logic          clr_l,
  output logic          set_r,
  output logic          clr_r,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  import dpm_pkg::*;
  localparam logic [AW-1:0] L_BOX = AW'(mbox_index(OWNER_LEFT, AW));
  localparam logic [AW-1:0] R_BOX = AW'(mbox_index(OWNER_RIGHT, AW));

  logic flag_l, flag_r;

  assign set_l = r_sel && r_we && r_any_be && (r_addr == L_BOX);
  assign clr_l = l_sel && !l_we && (l_addr == L_BOX);
  assign set_r = l_sel && l_we && l_any_be && (l_addr == R_BOX);
  assign clr_r = r_sel && !r_we && (r_addr == R_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_l <= 1'b0;
      flag_r <= 1'b0;
    end else begin
      if (set_l)      flag_l <= 1'b1;
      else if (clr_l) flag_l <= 1'b0;
      if (set_r)      flag_r <= 1'b1;
      else if (clr_r) flag_r <= 1'b0;
    end
  end

  assign l_irq_n = !flag_l;
  assign r_irq_n = !flag_r;
endmodule

// File: rtl/dpm_collide.sv
`timescale 1ns/1ps
module dpm_collide #(
  parameter int AW  = 6,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          r_sel,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          coll_ev,
  output logic          busy
);
  logic [LAT-1:0] line;

  assign coll_ev = l_sel && r_sel && (l_addr == r_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '0;
    else        line <= {line[LAT-2:0], coll_ev};
  end

  assign busy = line[LAT-1];
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox #(
  parameter int AW       = 6,
  parameter int LANES    = 4,
  parameter int BUSY_LAT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l_ce_n,
  input  logic               l_ce,
  input  logic               l_we,
  input  logic               l_oe_n,
  input  logic [AW-1:0]      l_addr,
  input  logic [LANES*8-1:0] l_wdata,
  input  logic [LANES-1:0]   l_be,
  output logic [LANES*8-1:0] l_rdata,
  output logic               l_irq_n,
  output logic               l_busy,
  input  logic               r_ce_n,
  input  logic               r_ce,
  input  logic               r_we,
  input  logic               r_oe_n,
  input  logic [AW-1:0]      r_addr,
  input  logic [LANES*8-1:0] r_wdata,
  input  logic [LANES-1:0]   r_be,
  output logic [LANES*8-1:0] r_rdata,
  output logic               r_irq_n,
  output logic               r_busy
);
  localparam int DW = LANES * 8;

  logic          ls_sel, ls_we, rs_sel, rs_we;
  logic [AW-1:0] ls_addr, rs_addr;
  logic [DW-1:0] ls_wdata, rs_wdata, l_word, r_word;
  logic [LANES-1:0] ls_be, rs_be;
  logic mb_set_l, mb_clr_l, mb_set_r, mb_clr_r;
  logic coll_ev, busy_any;

  dpm_port_reg #(.AW(AW), .LANES(LANES)) u_lreg (
    .clk(clk), .rst_n(rst_n), .ce_n(l_ce_n), .ce(l_ce), .we(l_we),
    .addr(l_addr), .wdata(l_wdata), .be(l_be),
    .sel_q(ls_sel), .we_q(ls_we), .addr_q(ls_addr), .wdata_q(ls_wdata), .be_q(ls_be));

  dpm_port_reg #(.AW(AW), .LANES(LANES)) u_rreg (
    .clk(clk), .rst_n(rst_n), .ce_n(r_ce_n), .ce(r_ce), .we(r_we),
    .addr(r_addr), .wdata(r_wdata), .be(r_be),
    .sel_q(rs_sel), .we_q(rs_we), .addr_q(rs_addr), .wdata_q(rs_wdata), .be_q(rs_be));

  dpm_array #(.AW(AW), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .l_sel(ls_sel), .l_we(ls_we), .l_addr(ls_addr), .l_wdata(ls_wdata), .l_be(ls_be),
    .r_sel(rs_sel), .r_we(rs_we), .r_addr(rs_addr), .r_wdata(rs_wdata), .r_be(rs_be),
    .l_rd(l_word), .r_rd(r_word));

  dpm_mailbox #(.AW(AW)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .l_sel(ls_sel), .l_we(ls_we), .l_addr(ls_addr), .l_any_be(|ls_be),
    .r_sel(rs_sel), .r_we(rs_we), .r_addr(rs_addr), .r_any_be(|rs_be),
    .set_l(mb_set_l), .clr_l(mb_clr_l), .set_r(mb_set_r), .clr_r(mb_clr_r),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n));

  dpm_collide #(.AW(AW), .LAT(BUSY_LAT)) u_coll (
    .clk(clk), .rst_n(rst_n), .l_sel(ls_sel), .r_sel(rs_sel),
    .l_addr(ls_addr), .r_addr(rs_addr), .coll_ev(coll_ev), .busy(busy_any));

  assign l_busy  = busy_any;
  assign r_busy  = busy_any;
  assign l_rdata = l_oe_n ? '0 : l_word;
  assign r_rdata = r_oe_n ? '0 : r_word;
endmodule

// File: rtl/dpm_checker.sv
`timescale 1ns/1ps
module dpm_checker #(
  parameter int DW  = 32,
  parameter int LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_oe_n,
  input logic          r_oe_n,
  input logic [DW-1:0] l_rdata,
  input logic [DW-1:0] r_rdata,
  input logic          l_irq_n,
  input logic          r_irq_n,
  input logic          l_busy,
  input logic          r_busy,
  input logic          set_l,
  input logic          clr_l,
  input logic          set_r,
  input logic          clr_r,
  input logic          coll_ev
);
  int unsigned pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 0;
    else        pend <= pend + (coll_ev ? 1 : 0) - (l_busy ? 1 : 0);
  end

  assert_irq_set_l_R6: assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !l_irq_n);
  assert_irq_set_r_R6: assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !r_irq_n);
  assert_irq_clr_l_R7: assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> l_irq_n);
  assert_irq_clr_r_R7: assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> r_irq_n);
  assert_irq_hold_l_R7: assert property (@(posedge clk) disable iff (!rst_n) (!set_l && !clr_l) |=> $stable(l_irq_n));
  assert_irq_hold_r_R7: assert property (@(posedge clk) disable iff (!rst_n) (!set_r && !clr_r) |=> $stable(r_irq_n));
  assert_busy_pair_R8: assert property (@(posedge clk) disable iff (!rst_n) l_busy == r_busy);
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n) l_busy |-> pend != 0);
  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n) pend <= LAT);
  assert_oe_gate_l_R5: assert property (@(posedge clk) disable iff (!rst_n) l_oe_n |-> l_rdata == '0);
  assert_oe_gate_r_R5: assert property (@(posedge clk) disable iff (!rst_n) r_oe_n |-> r_rdata == '0);
endmodule

bind dpram_mailbox dpm_checker #(.DW(LANES*8), .LAT(BUSY_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_oe_n(l_oe_n), .r_oe_n(r_oe_n),
  .l_rdata(l_rdata), .r_rdata(r_rdata), .l_irq_n(l_irq_n), .r_irq_n(r_irq_n),
  .l_busy(l_busy), .r_busy(r_busy), .set_l(mb_set_l), .clr_l(mb_clr_l),
  .set_r(mb_set_r), .clr_r(mb_clr_r), .coll_ev(coll_ev));

// File: tb/dpram_mailbox_test.sv
`timescale 1ns/1ps
module dpram_mailbox_test;
  localparam int AW = 6, LANES = 4, DW = 32, DEPTH = 64;
  localparam logic [AW-1:0] LBOX = 6'd63, RBOX = 6'd62;

  typedef struct packed {
    logic cen; logic ce; logic we; logic oen;
    logic [AW-1:0] a; logic [DW-1:0] d; logic [LANES-1:0] be;
  } pin_t;

  logic clk = 1'b0, rst_n = 1'b0;
  pin_t cl, cr;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n, l_busy, r_busy;

  always #4 clk = ~clk;

  dpram_mailbox #(.AW(AW), .LANES(LANES), .BUSY_LAT(5)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(cl.cen), .l_ce(cl.ce), .l_we(cl.we), .l_oe_n(cl.oen), .l_addr(cl.a),
    .l_wdata(cl.d), .l_be(cl.be), .l_rdata(l_rdata), .l_irq_n(l_irq_n), .l_busy(l_busy),
    .r_ce_n(cr.cen), .r_ce(cr.ce), .r_we(cr.we), .r_oe_n(cr.oen), .r_addr(cr.a),
    .r_wdata(cr.d), .r_be(cr.be), .r_rdata(r_rdata), .r_irq_n(r_irq_n), .r_busy(r_busy));

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] e_rd_l = '0, e_rd_r = '0;
  logic e_flag_l = 0, e_flag_r = 0;
  logic [4:0] e_line = '0;

  function automatic logic [DW-1:0] widen(input logic [LANES-1:0] be);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < LANES; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction
  function automatic bit picked(input pin_t p); return !p.cen && p.ce; endfunction
  function automatic pin_t idle(); pin_t p = '0; p.cen = 1; return p; endfunction
  function automatic pin_t rd(input logic [AW-1:0] a, input logic [LANES-1:0] be);
    pin_t p = '0; p.ce = 1; p.a = a; p.be = be; return p;
  endfunction
  function automatic pin_t wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LANES-1:0] be);
    pin_t p = rd(a, be); p.we = 1; p.d = d; return p;
  endfunction

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Effect of the inputs sampled on the last edge, applied at the coming edge.
  task automatic model(input pin_t pl, input pin_t pr);
    bit sl = picked(pl), sr = picked(pr);
    bit setl, clrl, setr, clrr;
    if (sl && !pl.we) e_rd_l = mdl[pl.a] & widen(pl.be);
    if (sr && !pr.we) e_rd_r = mdl[pr.a] & widen(pr.be);
    if (sr && pr.we) mdl[pr.a] = (mdl[pr.a] & ~widen(pr.be)) | (pr.d & widen(pr.be));
    if (sl && pl.we) mdl[pl.a] = (mdl[pl.a] & ~widen(pl.be)) | (pl.d & widen(pl.be));
    setl = sr && pr.we && (pr.be != 0) && pr.a == LBOX;
    clrl = sl && !pl.we && pl.a == LBOX;
    setr = sl && pl.we && (pl.be != 0) && pl.a == RBOX;
    clrr = sr && !pr.we && pr.a == RBOX;
    if (setl) e_flag_l = 1; else if (clrl) e_flag_l = 0;
    if (setr) e_flag_r = 1; else if (clrr) e_flag_r = 0;
    e_line = {e_line[3:0], sl && sr && pl.a == pr.a};
  endtask

  task automatic check_all(input string tag);
    chk(tag, "l_rdata", l_rdata, cl.oen ? '0 : e_rd_l);
    chk(tag, "r_rdata", r_rdata, cr.oen ? '0 : e_rd_r);
    chk(tag, "l_irq_n", DW'(l_irq_n), DW'(!e_flag_l));
    chk(tag, "r_irq_n", DW'(r_irq_n), DW'(!e_flag_r));
    chk(tag, "l_busy", DW'(l_busy), DW'(e_line[4]));
    chk(tag, "r_busy", DW'(r_busy), DW'(e_line[4]));
  endtask

  task automatic step(input pin_t nl, input pin_t nr, input string tag);
    @(negedge clk);
    check_all(tag);
    model(cl, cr);
    cl = nl; cr = nr;
  endtask

  task automatic settle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(idle(), idle(), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pin_t a, b;
    void'($urandom(32'd20240611));
    cl = idle(); cr = idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset state
    @(negedge clk); check_all("R10");

    // fill memory from the left port
    for (int i = 0; i < DEPTH; i++) step(wr(AW'(i), 32'h5A000000 ^ (i * 32'h00010203), 4'hF), idle(), "R3");
    settle(2, "R6");

    // R1: deselected writes by either enable leave memory unchanged
    a = wr(6'd5, 32'hDEADBEEF, 4'hF); a.cen = 1; step(a, idle(), "R1");
    a = wr(6'd5, 32'hDEADBEEF, 4'hF); a.ce = 0;  step(a, idle(), "R1");
    step(rd(6'd5, 4'hF), idle(), "R1"); settle(2, "R1");
    // R1: deselected read keeps rdata
    a = rd(6'd6, 4'hF); a.ce = 0; step(a, idle(), "R1"); settle(2, "R1");

    // R3 / R4: partial write, partial read
    step(wr(6'd10, 32'h11223344, 4'b0101), idle(), "R3");
    step(rd(6'd10, 4'hF), idle(), "R3");
    step(rd(6'd10, 4'b0010), idle(), "R4"); settle(2, "R4");

    // R2: read and write on the same edge see old data
    step(rd(6'd9, 4'hF), wr(6'd9, 32'hCAFEF00D, 4'hF), "R2");
    step(idle(), rd(6'd9, 4'hF), "R2"); settle(2, "R2");

    // R9: dual write on one address
    step(wr(6'd7, 32'hAAAAAAAA, 4'b0011), wr(6'd7, 32'h55555555, 4'b1110), "R9");
    step(rd(6'd7, 4'hF), idle(), "R9"); settle(6, "R9");

    // R8: single collision, then back-to-back collisions
    step(rd(6'd3, 4'hF), rd(6'd3, 4'hF), "R8"); settle(7, "R8");
    step(rd(6'd4, 4'hF), wr(6'd4, 32'h0, 4'h0), "R8");
    step(rd(6'd4, 4'hF), rd(6'd4, 4'hF), "R8"); settle(8, "R8");

    // R6 / R7: mailbox raise and clear both directions
    step(idle(), rd(RBOX, 4'hF), "R7");
    step(idle(), wr(LBOX, 32'h0000CAFE, 4'h1), "R6"); settle(2, "R6");
    step(rd(LBOX, 4'hF), idle(), "R7"); settle(2, "R7");
    step(wr(RBOX, 32'h12345678, 4'h8), idle(), "R6"); settle(2, "R6");
    step(idle(), rd(RBOX, 4'h1), "R7"); settle(2, "R7");
    // R6: zero byte-select write raises nothing
    step(idle(), wr(LBOX, 32'h1, 4'h0), "R6"); settle(2, "R6");
    // R7: own-mailbox write has no effect; raise beats clear
    step(wr(LBOX, 32'h77, 4'hF), idle(), "R7"); settle(2, "R7");
    step(rd(LBOX, 4'hF), wr(LBOX, 32'h99, 4'hF), "R7"); settle(7, "R7");
    step(rd(LBOX, 4'hF), idle(), "R7"); settle(2, "R7");

    // R5: output enable gates without a clock edge
    step(rd(6'd20, 4'hF), idle(), "R5"); settle(2, "R5");
    #1 cl.oen = 1; #1 chk("R5", "l_rdata gated", l_rdata, '0);
    cl.oen = 0; #1 chk("R5", "l_rdata open", l_rdata, e_rd_l);

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      a = '0; b = '0;
      a.cen = ($urandom % 6) == 0; a.ce = ($urandom % 8) != 0;
      b.cen = ($urandom % 6) == 0; b.ce = ($urandom % 8) != 0;
      a.we = $urandom % 2; b.we = $urandom % 2;
      a.oen = ($urandom % 5) == 0; b.oen = ($urandom % 5) == 0;
      a.a = (($urandom % 4) == 0) ? AW'(62 + $urandom % 2) : AW'($urandom % 8);
      b.a = (($urandom % 3) == 0) ? a.a : ((($urandom % 4) == 0) ? AW'(62 + $urandom % 2) : AW'($urandom % 8));
      a.d = $urandom; b.d = $urandom;
      a.be = $urandom; b.be = $urandom;
      step(a, b, "R2");
    end
    settle(8, "R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule